// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave

This block models a small serial memory as a master sees it on a two-wire bus. It holds 128 bytes. A system clock samples the bus clock and data lines. The block pulls the data line low through an open-drain enable, and it never drives the line high. After a START, the first byte gives the word address in its upper seven bits. Its least significant bit selects the operation: 0 writes and 1 reads. There is no separate device-select byte.

A write sends one to four data bytes and then a STOP. The bytes are collected in a page buffer. The STOP launches a timed write cycle, and the buffered bytes are placed in the array when that cycle ends. While the cycle runs, the block ignores the bus entirely, so a master polls for completion by repeating the first byte until it gets an acknowledge. A read returns the byte at the given address. The read continues through successive addresses for as long as the master acknowledges, wrapping from the top of memory to the bottom.

Top module: `serial_mem_slave`

## Requirements
- R1: After reset the slave does not drive the data line, no write cycle is running, and the first byte of a new transfer is acknowledged.
- R2: The first byte after START is shifted MSB first: bits 7..1 are the word address and bit 0 selects the operation (0 write, 1 read). In a write, the slave acknowledges the first byte and each data byte by holding the data line low during the ninth clock.
- R3: A STOP that follows at least one complete write data byte starts a write cycle lasting TWR_CYCLES system clocks. During that cycle the slave acknowledges nothing, and a complete write sent in that time leaves memory unchanged.
- R4: Once the write cycle has ended, the first byte of a polling attempt is acknowledged and the transfer continues normally.
- R5: A read acknowledges the first byte and then returns the stored byte at that address, MSB first.
- R6: In a page write, only the low two address bits advance after each data byte, so the bytes stay inside the aligned 4-byte page. Bytes sent from address 0x0A land at 0x0A, 0x0B, 0x08, 0x09.
- R7: When more than four data bytes are sent in one page write, the later bytes overwrite the earlier ones at the wrapped positions in the same page.
- R8: In a sequential read, each master acknowledge advances the full 7-bit address by one, with 127 followed by 0.
- R9: A master NACK after a read byte, followed by STOP, ends the read with the data line released.
- R10: A START and first byte followed by STOP, with no data byte, starts no write cycle.
- R11: A START in the middle of a byte aborts the transfer. A repeated START discards write bytes that have not yet been committed.
- R12: The slave changes its data-line drive only while the bus clock is low, so the data line stays stable while the bus clock is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the bus |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (wired) |
| sda_oe | output | 1 | 1 pulls the data line low; 0 releases it |

## Verification
The hardest case to reach is the window in which the write cycle is still running. Only there does the slave's refusal to respond, and its ignoring of a complete write, show at the ports. The stimulus sends a polling byte immediately after the STOP that launches the cycle. While the cycle is still running, it then pushes a full write to a known address. Afterwards it polls until the slave acknowledges, and it reads that address back to show the value was not touched.

// File: rtl/sms_pkg.sv
package sms_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_WR,
    ST_WACK,
    ST_RD,
    ST_RREL,
    ST_RSMP,
    ST_RNXT
  } sms_state_e;

endpackage

// File: rtl/sms_line_sync.sv
module sms_line_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [SYNC_STAGES-1:0] scl_sr, sda_sr;
  logic                   scl_q, sda_q;
  logic                   scl_s;

  assign scl_s = scl_sr[SYNC_STAGES-1];
  assign sda_s = sda_sr[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sr <= '1;
      sda_sr <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sr <= {scl_sr[SYNC_STAGES-2:0], scl_i};
      sda_sr <= {sda_sr[SYNC_STAGES-2:0], sda_i};
      scl_q  <= scl_s;
      sda_q  <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/sms_write_stage.sv
module sms_write_stage #(
  parameter int ADDR_W     = 7,
  parameter int DATA_W     = 8,
  parameter int PAGE_W     = 2,
  parameter int TWR_CYCLES = 5000
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  wr_en,
  input  logic [ADDR_W-1:0]                     wr_addr,
  input  logic [DATA_W-1:0]                     wr_data,
  input  logic                                  discard,
  input  logic                                  launch,
  output logic                                  busy,
  output logic                                  commit,
  output logic [ADDR_W-PAGE_W-1:0]              commit_base,
  output logic [(1<<PAGE_W)-1:0]                commit_valid,
  output logic [(1<<PAGE_W)-1:0][DATA_W-1:0]    commit_data
);

  localparam int SLOTS  = 1 << PAGE_W;
  localparam int BASE_W = ADDR_W - PAGE_W;
  localparam int TMR_W  = $clog2(TWR_CYCLES + 1);

  logic                         busy_q, busy_n;
  logic [TMR_W-1:0]             tmr_q, tmr_n;
  logic [SLOTS-1:0]             valid_q, valid_n;
  logic [SLOTS-1:0][DATA_W-1:0] data_q, data_n;
  logic [BASE_W-1:0]            base_q, base_n;
  logic                         last_tick;

  assign last_tick = busy_q && (tmr_q == TMR_W'(1));

  always_comb begin
    busy_n  = busy_q;
    tmr_n   = tmr_q;
    valid_n = valid_q;
    data_n  = data_q;
    base_n  = base_q;
    if (busy_q) begin
      if (last_tick) begin
        busy_n  = 1'b0;
        valid_n = '0;
      end else begin
        tmr_n = tmr_q - TMR_W'(1);
      end
    end else if (discard) begin
      valid_n = '0;
    end else if (launch && (|valid_q)) begin
      busy_n = 1'b1;
      tmr_n  = TMR_W'(TWR_CYCLES);
    end else if (wr_en) begin
      data_n[wr_addr[PAGE_W-1:0]]  = wr_data;
      valid_n[wr_addr[PAGE_W-1:0]] = 1'b1;
      base_n                       = wr_addr[ADDR_W-1:PAGE_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      tmr_q   <= '0;
      valid_q <= '0;
      data_q  <= '0;
      base_q  <= '0;
    end else begin
      busy_q  <= busy_n;
      tmr_q   <= tmr_n;
      valid_q <= valid_n;
      data_q  <= data_n;
      base_q  <= base_n;
    end
  end

  assign busy         = busy_q;
  assign commit       = last_tick;
  assign commit_base  = base_q;
  assign commit_valid = valid_q;
  assign commit_data  = data_q;

endmodule

// File: rtl/sms_mem_core.sv
module sms_mem_core #(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8,
  parameter int PAGE_W = 2
) (
  input  logic                               clk,
  input  logic                               commit,
  input  logic [ADDR_W-PAGE_W-1:0]           commit_base,
  input  logic [(1<<PAGE_W)-1:0]             commit_valid,
  input  logic [(1<<PAGE_W)-1:0][DATA_W-1:0] commit_data,
  input  logic [ADDR_W-1:0]                  rd_addr,
  output logic [DATA_W-1:0]                  rd_data
);

  localparam int DEPTH = 1 << ADDR_W;
  localparam int SLOTS = 1 << PAGE_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (commit) begin
      for (int k = 0; k < SLOTS; k++) begin
        if (commit_valid[k]) begin
          mem[{commit_base, PAGE_W'(k)}] <= commit_data[k];
        end
      end
    end
  end

  assign rd_data = mem[rd_addr];

endmodule

// File: rtl/sms_xfer_fsm.sv
module sms_xfer_fsm
  import sms_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8,
  parameter int PAGE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              busy,
  input  logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] addr,
  output logic              wr_en,
  output logic [DATA_W-1:0] wr_data,
  output logic              sda_oe,
  output logic              idle
);

  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  sms_state_e         state_q, state_n;
  logic               phase_q, phase_n;
  logic [CNT_W-1:0]   cnt_q, cnt_n;
  logic [DATA_W-1:0]  sh_q, sh_n;
  logic [ADDR_W-1:0]  addr_q, addr_n;
  logic               rw_q, rw_n;
  logic               oe_q, oe_n;
  logic [DATA_W-1:0]  byte_in;

  assign byte_in = {sh_q[DATA_W-2:0], sda_s};

  always_comb begin
    state_n = state_q;
    phase_n = phase_q;
    cnt_n   = cnt_q;
    sh_n    = sh_q;
    addr_n  = addr_q;
    rw_n    = rw_q;
    oe_n    = oe_q;
    wr_en   = 1'b0;
    if (busy) begin
      state_n = ST_IDLE;
      oe_n    = 1'b0;
    end else if (start_det) begin
      state_n = ST_ADDR;
      cnt_n   = '0;
      phase_n = 1'b0;
      oe_n    = 1'b0;
    end else if (stop_det) begin
      state_n = ST_IDLE;
      oe_n    = 1'b0;
    end else begin
      unique case (state_q)
        ST_ADDR: if (scl_rise) begin
          sh_n  = byte_in;
          cnt_n = cnt_q + CNT_W'(1);
          if (cnt_q == LAST) begin
            addr_n  = byte_in[DATA_W-1:1];
            rw_n    = byte_in[0];
            phase_n = 1'b0;
            state_n = ST_AACK;
          end
        end
        ST_AACK: if (scl_fall) begin
          if (!phase_q) begin
            oe_n    = 1'b1;
            phase_n = 1'b1;
          end else begin
            phase_n = 1'b0;
            cnt_n   = '0;
            if (rw_q) begin
              oe_n    = ~rd_data[DATA_W-1];
              state_n = ST_RD;
            end else begin
              oe_n    = 1'b0;
              state_n = ST_WR;
            end
          end
        end
        ST_WR: if (scl_rise) begin
          sh_n  = byte_in;
          cnt_n = cnt_q + CNT_W'(1);
          if (cnt_q == LAST) begin
            wr_en   = 1'b1;
            addr_n  = {addr_q[ADDR_W-1:PAGE_W], addr_q[PAGE_W-1:0] + PAGE_W'(1)};
            phase_n = 1'b0;
            state_n = ST_WACK;
          end
        end
        ST_WACK: if (scl_fall) begin
          if (!phase_q) begin
            oe_n    = 1'b1;
            phase_n = 1'b1;
          end else begin
            oe_n    = 1'b0;
            phase_n = 1'b0;
            cnt_n   = '0;
            state_n = ST_WR;
          end
        end
        ST_RD: begin
          if (scl_rise) begin
            cnt_n = cnt_q + CNT_W'(1);
            if (cnt_q == LAST) state_n = ST_RREL;
          end else if (scl_fall) begin
            oe_n = ~rd_data[LAST - cnt_q];
          end
        end
        ST_RREL: if (scl_fall) begin
          oe_n    = 1'b0;
          state_n = ST_RSMP;
        end
        ST_RSMP: if (scl_rise) begin
          if (!sda_s) begin
            addr_n  = addr_q + ADDR_W'(1);
            state_n = ST_RNXT;
          end else begin
            state_n = ST_IDLE;
          end
        end
        ST_RNXT: if (scl_fall) begin
          oe_n    = ~rd_data[DATA_W-1];
          cnt_n   = '0;
          state_n = ST_RD;
        end
        default: state_n = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      phase_q <= 1'b0;
      cnt_q   <= '0;
      sh_q    <= '0;
      addr_q  <= '0;
      rw_q    <= 1'b0;
      oe_q    <= 1'b0;
    end else begin
      state_q <= state_n;
      phase_q <= phase_n;
      cnt_q   <= cnt_n;
      sh_q    <= sh_n;
      addr_q  <= addr_n;
      rw_q    <= rw_n;
      oe_q    <= oe_n;
    end
  end

  assign addr    = addr_q;
  assign wr_data = byte_in;
  assign sda_oe  = oe_q;
  assign idle    = (state_q == ST_IDLE);

endmodule

// File: rtl/serial_mem_slave.sv
module serial_mem_slave #(
  parameter int ADDR_W      = 7,
  parameter int DATA_W      = 8,
  parameter int PAGE_W      = 2,
  parameter int TWR_CYCLES  = 5000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe
);

  localparam int SLOTS  = 1 << PAGE_W;
  localparam int BASE_W = ADDR_W - PAGE_W;

  logic                         sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic                         busy, commit, wr_en, fsm_idle;
  logic [ADDR_W-1:0]            addr;
  logic [DATA_W-1:0]            wr_data, rd_data;
  logic [BASE_W-1:0]            commit_base;
  logic [SLOTS-1:0]             commit_valid;
  logic [SLOTS-1:0][DATA_W-1:0] commit_data;

  sms_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  sms_xfer_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_W(PAGE_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .busy(busy), .rd_data(rd_data), .addr(addr), .wr_en(wr_en),
    .wr_data(wr_data), .sda_oe(sda_oe), .idle(fsm_idle)
  );

  sms_write_stage #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_W(PAGE_W), .TWR_CYCLES(TWR_CYCLES)
  ) u_wstage (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(addr), .wr_data(wr_data),
    .discard(start_det), .launch(stop_det), .busy(busy), .commit(commit),
    .commit_base(commit_base), .commit_valid(commit_valid), .commit_data(commit_data)
  );

  sms_mem_core #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_W(PAGE_W)) u_mem (
    .clk(clk), .commit(commit), .commit_base(commit_base),
    .commit_valid(commit_valid), .commit_data(commit_data),
    .rd_addr(addr), .rd_data(rd_data)
  );

endmodule

// File: rtl/sms_checker.sv
module sms_checker (
  input logic clk,
  input logic rst_n,
  input logic scl_i,
  input logic sda_oe,
  input logic busy,
  input logic stop_det,
  input logic fsm_idle
);

  AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> !scl_i); // R12

  AST_BUSY_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !sda_oe); // R3

  AST_BUSY_FSM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> fsm_idle); // R3

  AST_BUSY_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(stop_det)); // R3

  AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe); // R9

endmodule

bind serial_mem_slave sms_checker u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe),
  .busy(busy), .stop_det(stop_det), .fsm_idle(fsm_idle)
);

// File: tb/sim_serial_mem_slave.sv
module sim_serial_mem_slave;

  localparam int Q   = 4;
  localparam int TWR = 1500;
  localparam int NV  = 6;
  localparam logic [14:0] VEC [NV] = '{
    {7'h05, 8'h3C}, {7'h7F, 8'hE1}, {7'h00, 8'h5A},
    {7'h01, 8'h96}, {7'h20, 8'h0F}, {7'h30, 8'hC8}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe;
  logic sda_bus;
  int   checks = 0;
  int   errors = 0;
  int   glitches = 0;

  always #2 clk = ~clk;
  assign sda_bus = sda_m & ~sda_oe;

  serial_mem_slave #(.TWR_CYCLES(TWR)) u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe(sda_oe)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(2*Q);
    sda_m = 1'b0; tick(2*Q);
    scl_m = 1'b0;
  endtask

  task automatic bus_stop();
    tick(Q); sda_m = 1'b0; tick(Q);
    scl_m = 1'b1; tick(2*Q);
    sda_m = 1'b1; tick(2*Q);
  endtask

  task automatic send_bit(input logic b);
    tick(Q); sda_m = b; tick(Q);
    scl_m = 1'b1; tick(2*Q);
    scl_m = 1'b0;
  endtask

  task automatic recv_bit(output logic b);
    logic s1;
    tick(Q); sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    s1 = sda_bus; tick(Q);
    b = sda_bus;
    if (s1 != b) glitches++;
    scl_m = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] v, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
    recv_bit(b);
    ack = ~b;
  endtask

  task automatic recv_byte(input logic m_ack, output logic [7:0] v);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      recv_bit(b);
      v[i] = b;
    end
    send_bit(~m_ack);
  endtask

  task automatic wait_ready(output logic ok);
    logic a;
    ok = 1'b0;
    for (int t = 0; t < 60 && !ok; t++) begin
      bus_start();
      send_byte(8'h00, a);
      bus_stop();
      ok = a;
    end
  endtask

  task automatic read_one(input logic [6:0] a, output logic [7:0] v);
    logic k;
    bus_start();
    send_byte({a, 1'b1}, k);
    recv_byte(1'b0, v);
    bus_stop();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic       ack, rdy;
    logic [7:0] v;
    tick(5);
    check(sda_oe == 1'b0, "R1 oe during reset", sda_oe, 0);
    rst_n = 1'b1;
    tick(5);
    check(sda_oe == 1'b0, "R1 oe after reset", sda_oe, 0);
    bus_start(); send_byte(8'h00, ack); bus_stop();
    check(ack, "R1 first byte acked", ack, 1);

    // byte write then byte read over the vector table (R2, R5)
    for (int n = 0; n < NV; n++) begin
      bus_start();
      send_byte({VEC[n][14:8], 1'b0}, ack);
      check(ack, "R2 address ack", ack, 1);
      send_byte(VEC[n][7:0], ack);
      check(ack, "R2 data ack", ack, 1);
      bus_stop();
      wait_ready(rdy);
      read_one(VEC[n][14:8], v);
      check(v == VEC[n][7:0], "R5 read back", v, VEC[n][7:0]);
    end

    // R3: silent while busy, write ignored
    bus_start(); send_byte({7'h40, 1'b0}, ack); send_byte(8'h11, ack); bus_stop();
    bus_start(); send_byte({7'h30, 1'b0}, ack);
    check(!ack, "R3 poll nacked while busy", ack, 0);
    send_byte(8'h55, ack); bus_stop();
    wait_ready(rdy);
    // R4: poll accepted after cycle, transfer continues
    bus_start(); send_byte({7'h41, 1'b0}, ack);
    check(ack, "R4 poll acked after cycle", ack, 1);
    send_byte(8'h22, ack);
    check(ack, "R4 data acked after poll", ack, 1);
    bus_stop();
    wait_ready(rdy);
    read_one(7'h30, v);
    check(v == 8'hC8, "R3 busy write ignored", v, 8'hC8);
    read_one(7'h40, v);
    check(v == 8'h11, "R3 committed byte", v, 8'h11);
    check(sda_oe == 1'b0, "R9 released after nack stop", sda_oe, 0);

    // R6: page write from 0x0A
    bus_start(); send_byte({7'h0A, 1'b0}, ack);
    for (int i = 0; i < 4; i++) send_byte(8'hA0 + 8'(i), ack);
    bus_stop(); wait_ready(rdy);
    bus_start(); send_byte({7'h08, 1'b1}, ack);
    for (int i = 0; i < 4; i++) begin
      logic [7:0] e;
      e = (i < 2) ? 8'hA2 + 8'(i) : 8'hA0 + 8'(i - 2);
      recv_byte(i < 3, v);
      check(v == e, "R6 page placement", v, e);
    end
    bus_stop();

    // R7: six bytes into page at 0x10
    bus_start(); send_byte({7'h10, 1'b0}, ack);
    for (int i = 0; i < 6; i++) send_byte(8'hB0 + 8'(i), ack);
    bus_stop(); wait_ready(rdy);
    bus_start(); send_byte({7'h10, 1'b1}, ack);
    for (int i = 0; i < 4; i++) begin
      logic [7:0] e;
      e = (i < 2) ? 8'hB4 + 8'(i) : 8'hB0 + 8'(i);
      recv_byte(i < 3, v);
      check(v == e, "R7 page overwrite", v, e);
    end
    bus_stop();

    // R8: sequential read across 127 -> 0
    bus_start(); send_byte({7'h7F, 1'b1}, ack);
    recv_byte(1'b1, v); check(v == 8'hE1, "R8 seq byte 0x7F", v, 8'hE1);
    recv_byte(1'b1, v); check(v == 8'h5A, "R8 seq byte 0x00", v, 8'h5A);
    recv_byte(1'b0, v); check(v == 8'h96, "R8 seq byte 0x01", v, 8'h96);
    bus_stop();
    check(sda_oe == 1'b0, "R9 oe after read end", sda_oe, 0);

    // R10: address-only write starts no cycle
    bus_start(); send_byte({7'h05, 1'b0}, ack); bus_stop();
    bus_start(); send_byte({7'h05, 1'b0}, ack); bus_stop();
    check(ack, "R10 no cycle after empty write", ack, 1);

    // R11: abort mid-byte, repeated START discards buffered write
    bus_start();
    for (int i = 0; i < 4; i++) send_bit(i[0]);
    bus_start();
    send_byte({7'h20, 1'b0}, ack);
    check(ack, "R11 ack after mid-byte restart", ack, 1);
    send_byte(8'hC3, ack);
    bus_start();
    send_byte({7'h20, 1'b1}, ack);
    recv_byte(1'b0, v);
    bus_stop();
    check(v == 8'h0F, "R11 buffered byte discarded", v, 8'h0F);
    bus_start(); send_byte({7'h20, 1'b0}, ack); bus_stop();
    check(ack, "R11 no cycle after discard", ack, 1);

    check(glitches == 0, "R12 data stable while SCL high", glitches, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule